// File: doc/BRIEF.md
# Double-Data-Rate Write Burst Capture

This block is the memory-side write path of a double-data-rate SDRAM with a two-beat prefetch. A write command names a bank, a starting column and whether the row should be closed once the burst ends. The block then collects data beats on both edges of the incoming data strobe. The beat on the rising edge and the beat on the falling edge that follows it form one pair, and that pair is stored into a small behavioural array as one write. Each byte lane is gated by its own mask bit.

All burst bookkeeping runs in the command clock domain. A new write, or a read, may arrive while a burst is still in flight. A write cuts the older burst short or chains onto it with no gap in the data stream. A read stops the burst at a pair boundary. The block raises a one-cycle completion pulse once the write postamble is over. For an auto-precharge burst, a precharge request for the bank comes with that pulse. A read port on the array lets the surrounding model inspect the stored words.

Top module: `ddr_wr_capture`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `burst_done` and `pre_req` are low.
- R2: For a write command sampled at clock edge k, pair j (j counted from 0) is the rising-strobe beat at k+tDQSS+j cycles and the falling beat half a cycle later. tDQSS may be anything from 0.75 to 1.25 clock periods. Both beats of the pair are stored.
- R3: Bit 0 of the command column is ignored, so the burst starts at an even column. Beat b goes to column `blk | ((start + b) mod BL)`. Here `blk` is the start column with its low log2(BL) bits cleared, and BL defaults to 4.
- R4: Byte lane i (bits 8i+7..8i) of a beat is stored only when `dm[i]` is 0 during that beat. When `dm[i]` is 1 the stored byte is unchanged. The two beats of a pair are masked independently.
- R5: For a full burst commanded at edge k, `burst_done` is high for exactly the one clock cycle that follows edge k+BL/2+1.
- R6: When the finishing burst had its auto-precharge flag set, `pre_req` is high in the same cycle as `burst_done`, and `pre_bank` holds that burst's bank. Otherwise `pre_req` stays low.
- R7: Strobe edges and data that arrive with no burst in flight change nothing in the array and raise no completion pulse.
- R8: A write sampled BL/2 cycles after the previous one extends the data stream without a gap. No `burst_done` appears between the two bursts, and both bursts are stored completely.
- R9: A write sampled x cycles after an earlier one (x < BL/2) keeps only the first x pairs of the earlier burst. The earlier burst's remaining columns keep their old contents, and the new burst's pairs follow at once.
- R10: A read sampled at edge r keeps only the pairs whose slot opened at or before edge r, that is pairs j with k+1+j <= r. Later beats are discarded. `burst_done`, together with `pre_req` if the burst has auto-precharge, is high in the cycle after edge r+1.
- R11: A write and a read sampled at the same edge: the read wins, the write is dropped, and its data is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Write command strobe, sampled on rising `clk` |
| cmd_rd | input | 1 | Read command strobe, used only to cut a write burst |
| cmd_bank | input | BANK_W | Bank of the write |
| cmd_col | input | COL_W | Starting column of the write |
| cmd_ap | input | 1 | Close the row after the burst |
| dqs | input | 1 | Data strobe; both edges capture data |
| dq | input | 8*DQ_BYTES | Write data |
| dm | input | DQ_BYTES | Byte masks, high to skip the byte |
| rd_bank | input | BANK_W | Array inspection bank |
| rd_col | input | COL_W | Array inspection column |
| rd_data | output | 8*DQ_BYTES | Stored word at `rd_bank`/`rd_col` |
| burst_done | output | 1 | One-cycle pulse when a burst ends |
| pre_req | output | 1 | Precharge request, with `burst_done` |
| pre_bank | output | BANK_W | Bank to precharge |

## Verification
The bench runs bursts at the earliest, nominal and latest strobe delays. If the write slot were held open against the wrong clock edge, the pair would land in a neighbouring column or be lost at one end of the delay window. Odd and wrapping start columns show up a design that does not clear bit 0 or that carries past the burst block. A back-to-back write, a write one cycle after another, and a read one cycle after a write test the pair boundary. A design off by one there keeps a pair it should drop, drops one it should keep, or pulses completion in the middle of a chained stream. Stray strobes and a read issued together with a write catch a design that stores data with no burst in flight.

// File: rtl/ddrw_pkg.sv
`timescale 1ns/1ps
// Shared helpers for the write burst capture block.
// Assumes the burst length is a power of two.
package ddrw_pkg;
    // Offset of the rising beat of a pair inside its wrapped burst block.
    function automatic int unsigned rise_offset(input int unsigned start_off,
                                                input int unsigned pair_idx,
                                                input int unsigned bl);
        return (start_off + 2 * pair_idx) % bl;
    endfunction
endpackage

// File: rtl/ddrw_sched.sv
`timescale 1ns/1ps
// Burst scheduler in the command clock domain.
// Accepts a write into a one-cycle pending stage. Then it opens one slot per
// clock for each beat pair. Slot j spans edges k+1+j to k+2+j, which encloses
// the falling strobe edge of pair j for any tDQSS in 0.75..1.25 tCK.
// A newer write replaces the slot sequence. A read closes it one edge later.
// Assumes BL is 2, 4 or 8 and COL_W > log2(BL).
module ddrw_sched #(
    parameter int BANK_W = 2,
    parameter int COL_W  = 4,
    parameter int BL     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              cmd_rd,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              cmd_ap,
    output logic              slot_v,
    output logic [BANK_W-1:0] slot_bank,
    output logic [COL_W-1:0]  slot_col,
    output logic              burst_done,
    output logic              pre_req,
    output logic [BANK_W-1:0] pre_bank
);
    localparam int PAIRS = BL / 2;
    localparam int IDX_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;
    localparam int OFF_W = $clog2(BL);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(PAIRS - 1);

    logic              pend_v, pend_ap, rd_q;
    logic [BANK_W-1:0] pend_bank;
    logic [COL_W-1:0]  pend_col;
    logic [IDX_W-1:0]  slot_idx, nxt_idx;
    logic [COL_W-1:0]  s_start, nxt_start;
    logic [BANK_W-1:0] nxt_bank;
    logic              s_ap, nxt_ap, nxt_v;
    logic              done_q, pre_q;
    logic [BANK_W-1:0] pre_bank_q;
    logic [OFF_W-1:0]  off;

    // Register an accepted write; a read sampled at the same edge wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_ap   <= 1'b0;
            pend_bank <= '0;
            pend_col  <= '0;
            rd_q      <= 1'b0;
        end else begin
            pend_v    <= cmd_wr & ~cmd_rd;
            pend_ap   <= cmd_ap;
            pend_bank <= cmd_bank;
            pend_col  <= cmd_col & ~COL_W'(1);
            rd_q      <= cmd_rd;
        end
    end

    // Next slot state: load a new burst, close on last pair or read, else step.
    always_comb begin
        nxt_v     = slot_v;
        nxt_idx   = slot_idx;
        nxt_start = s_start;
        nxt_bank  = slot_bank;
        nxt_ap    = s_ap;
        if (pend_v) begin
            nxt_v     = 1'b1;
            nxt_idx   = '0;
            nxt_start = pend_col;
            nxt_bank  = pend_bank;
            nxt_ap    = pend_ap;
        end else if (slot_v && (rd_q || slot_idx == LAST)) begin
            nxt_v = 1'b0;
        end else if (slot_v) begin
            nxt_idx = slot_idx + 1'b1;
        end
    end

    // Slot registers plus completion and precharge pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_v     <= 1'b0;
            slot_idx   <= '0;
            s_start    <= '0;
            slot_bank  <= '0;
            s_ap       <= 1'b0;
            done_q     <= 1'b0;
            pre_q      <= 1'b0;
            pre_bank_q <= '0;
        end else begin
            slot_v     <= nxt_v;
            slot_idx   <= nxt_idx;
            s_start    <= nxt_start;
            slot_bank  <= nxt_bank;
            s_ap       <= nxt_ap;
            done_q     <= slot_v & ~nxt_v;
            pre_q      <= slot_v & ~nxt_v & s_ap;
            pre_bank_q <= slot_bank;
        end
    end

    // Column of the rising beat of the current pair, wrapped inside the block.
    always_comb begin
        off      = OFF_W'(ddrw_pkg::rise_offset(int'(s_start[OFF_W-1:0]),
                                                int'(slot_idx), BL));
        slot_col = {s_start[COL_W-1:OFF_W], off};
    end

    assign burst_done = done_q;
    assign pre_req    = pre_q;
    assign pre_bank   = pre_bank_q;

    // R5: the completion pulse follows a slot that has just closed.
    a_r5_done_after_slot: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> (!slot_v && $past(slot_v)));
    // R5: the completion pulse lasts one cycle.
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> !burst_done);
    // R2: pairs of one burst are visited in order, one per clock.
    a_r2_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_v && $past(slot_v) && !$past(pend_v) && !$past(rd_q))
        |-> slot_idx == IDX_W'($past(slot_idx) + 1'b1));
    // R10: a read closes the burst at the next edge.
    a_r10_read_cut: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_q) |-> !slot_v);
    // R6: a precharge request only comes with a completion pulse.
    a_r6_pre_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        pre_req |-> burst_done);
    // R11: a write sampled together with a read opens no burst.
    a_r11_read_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_rd && !slot_v && !pend_v) |=> ##1 !slot_v);
endmodule

// File: rtl/ddrw_rise_cap.sv
`timescale 1ns/1ps
// Holds the beat and masks presented on the rising strobe edge until the
// falling edge completes the pair. Assumes the strobe is clean and low outside
// bursts, as preamble and postamble rules guarantee.
module ddrw_rise_cap #(
    parameter int DW = 16,
    parameter int NB = 2
) (
    input  logic          dqs,
    input  logic [DW-1:0] dq,
    input  logic [NB-1:0] dm,
    output logic [DW-1:0] rise_dq,
    output logic [NB-1:0] rise_dm
);
    // Sample the first beat of each pair.
    always_ff @(posedge dqs) begin
        rise_dq <= dq;
        rise_dm <= dm;
    end
endmodule

// File: rtl/ddrw_array.sv
`timescale 1ns/1ps
// Behavioural storage array. On each falling strobe edge inside an open slot
// it stores one pair: the held rising beat at the even column and the present
// beat at the odd column, each byte gated by its own mask bit.
// The contents are not reset.
module ddrw_array #(
    parameter int DW     = 16,
    parameter int NB     = 2,
    parameter int BANK_W = 2,
    parameter int COL_W  = 4
) (
    input  logic              dqs,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [DW-1:0]     rise_dq,
    input  logic [NB-1:0]     rise_dm,
    input  logic [DW-1:0]     fall_dq,
    input  logic [NB-1:0]     fall_dm,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [COL_W-1:0]  rd_col,
    output logic [DW-1:0]     rd_data
);
    localparam int BANKS = 1 << BANK_W;
    localparam int COLS  = 1 << COL_W;

    logic [DW-1:0]    mem [BANKS][COLS];
    logic [COL_W-1:0] col_e, col_o;

    assign col_e = {wr_col[COL_W-1:1], 1'b0};
    assign col_o = {wr_col[COL_W-1:1], 1'b1};

    // Commit one beat pair, lane by lane, under the masks.
    always_ff @(negedge dqs) begin
        if (wr_en) begin
            for (int i = 0; i < NB; i++) begin
                if (!rise_dm[i]) mem[wr_bank][col_e][i*8 +: 8] <= rise_dq[i*8 +: 8];
                if (!fall_dm[i]) mem[wr_bank][col_o][i*8 +: 8] <= fall_dq[i*8 +: 8];
            end
        end
    end

    assign rd_data = mem[rd_bank][rd_col];
endmodule

// File: rtl/ddr_wr_capture.sv
`timescale 1ns/1ps
// Top of the write burst capture path. The clock-domain scheduler decides
// which pair slot is open. The strobe-domain capture and array store pairs
// while a slot is open. Assumes tDQSS in 0.75..1.25 tCK and a static burst length.
module ddr_wr_capture #(
    parameter int DQ_BYTES  = 2,
    parameter int BANK_W    = 2,
    parameter int COL_W     = 4,
    parameter int BURST_LEN = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_wr,
    input  logic                  cmd_rd,
    input  logic [BANK_W-1:0]     cmd_bank,
    input  logic [COL_W-1:0]      cmd_col,
    input  logic                  cmd_ap,
    input  logic                  dqs,
    input  logic [8*DQ_BYTES-1:0] dq,
    input  logic [DQ_BYTES-1:0]   dm,
    input  logic [BANK_W-1:0]     rd_bank,
    input  logic [COL_W-1:0]      rd_col,
    output logic [8*DQ_BYTES-1:0] rd_data,
    output logic                  burst_done,
    output logic                  pre_req,
    output logic [BANK_W-1:0]     pre_bank
);
    localparam int DW = 8 * DQ_BYTES;

    logic              slot_v;
    logic [BANK_W-1:0] slot_bank;
    logic [COL_W-1:0]  slot_col;
    logic [DW-1:0]     rise_dq;
    logic [DQ_BYTES-1:0] rise_dm;

    ddrw_sched #(.BANK_W(BANK_W), .COL_W(COL_W), .BL(BURST_LEN)) sched_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_rd(cmd_rd),
        .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cmd_ap(cmd_ap),
        .slot_v(slot_v), .slot_bank(slot_bank), .slot_col(slot_col),
        .burst_done(burst_done), .pre_req(pre_req), .pre_bank(pre_bank)
    );

    ddrw_rise_cap #(.DW(DW), .NB(DQ_BYTES)) cap_i (
        .dqs(dqs), .dq(dq), .dm(dm), .rise_dq(rise_dq), .rise_dm(rise_dm)
    );

    ddrw_array #(.DW(DW), .NB(DQ_BYTES), .BANK_W(BANK_W), .COL_W(COL_W)) arr_i (
        .dqs(dqs), .wr_en(slot_v), .wr_bank(slot_bank), .wr_col(slot_col),
        .rise_dq(rise_dq), .rise_dm(rise_dm), .fall_dq(dq), .fall_dm(dm),
        .rd_bank(rd_bank), .rd_col(rd_col), .rd_data(rd_data)
    );
endmodule

// File: tb/ddr_wr_capture_tb_top.sv
`timescale 1ns/1ps
module ddr_wr_capture_tb_top;
    localparam int BL = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0, cmd_rd = 1'b0, cmd_ap = 1'b0;
    logic [1:0]  cmd_bank = '0;
    logic [3:0]  cmd_col = '0;
    logic        dqs = 1'b0;
    logic [15:0] dq = '0;
    logic [1:0]  dm = '0;
    logic [1:0]  rd_bank = '0;
    logic [3:0]  rd_col = '0;
    logic [15:0] rd_data;
    logic        burst_done, pre_req;
    logic [1:0]  pre_bank;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] ref_mem [4][16];

    ddr_wr_capture #(.DQ_BYTES(2), .BANK_W(2), .COL_W(4), .BURST_LEN(BL)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_rd(cmd_rd),
        .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cmd_ap(cmd_ap),
        .dqs(dqs), .dq(dq), .dm(dm), .rd_bank(rd_bank), .rd_col(rd_col),
        .rd_data(rd_data), .burst_done(burst_done), .pre_req(pre_req),
        .pre_bank(pre_bank)
    );

    always #2.5 clk = ~clk;

    typedef struct packed {
        logic [1:0]  bank;
        logic [3:0]  col;
        logic        ap;
        logic [1:0]  dsel;
        logic [7:0]  seed;
        logic [15:0] mask;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'd0, 4'd0,  1'b0, 2'd0, 8'hA1, 16'h0000},
        '{2'd1, 4'd2,  1'b1, 2'd1, 8'hB2, 16'h0099},
        '{2'd2, 4'd7,  1'b0, 2'd2, 8'hC3, 16'h00F0},
        '{2'd3, 4'd4,  1'b1, 2'd0, 8'hD4, 16'h000F},
        '{2'd0, 4'd9,  1'b1, 2'd2, 8'hE5, 16'h0066},
        '{2'd2, 4'd14, 1'b0, 2'd1, 8'hF6, 16'h0000}
    };

    function automatic logic [15:0] beat(input logic [7:0] s, input int b);
        return {s, s ^ 8'(b * 37 + 1)} ^ 16'(b * 16'h0911);
    endfunction

    function automatic real dly(input logic [1:0] sel);
        return (sel == 2'd0) ? 3.75 : ((sel == 2'd1) ? 5.0 : 6.25);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference update for pair j of a burst (R3 column order, R4 masks).
    task automatic commit_pair(input logic [1:0] bank, input logic [3:0] col,
                               input logic [7:0] seed, input logic [15:0] mask,
                               input int j);
        int base = int'(col) & 14;
        int blk  = base & ~(BL - 1);
        int off  = base & (BL - 1);
        for (int h = 0; h < 2; h++) begin
            int bb = 2 * j + h;
            int c  = blk | ((off + bb) % BL);
            logic [15:0] v = beat(seed, bb);
            logic [1:0] mm = mask[2*bb +: 2];
            for (int i = 0; i < 2; i++)
                if (!mm[i]) ref_mem[bank][c][i*8 +: 8] = v[i*8 +: 8];
        end
    endtask

    task automatic drive_strobe(input real d, input int np, input logic [7:0] seed,
                                input logic [15:0] mask);
        #(d - 1.0);
        for (int b = 0; b < 2 * np; b++) begin
            dq = beat(seed, b);
            dm = mask[(2 * b) % 16 +: 2];
            #1.0;
            dqs = (b % 2 == 0);
            #1.5;
        end
    endtask

    // Call at a falling clock edge; returns at the falling edge after the command edge.
    task automatic issue_wr(input logic [1:0] bank, input logic [3:0] col,
                            input logic ap, input real d, input int np,
                            input logic [7:0] seed, input logic [15:0] mask);
        cmd_wr = 1'b1; cmd_bank = bank; cmd_col = col; cmd_ap = ap;
        @(posedge clk);
        fork
            drive_strobe(d, np, seed, mask);
        join_none
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic check_bank(input logic [1:0] b, input string tag);
        bit ok = 1'b1;
        logic [31:0] a = '0, e = '0;
        for (int c = 0; c < 16; c++) begin
            rd_bank = b; rd_col = 4'(c);
            #0.1;
            if (ok && rd_data !== ref_mem[b][c]) begin
                ok = 1'b0;
                a = {12'(c), rd_data};
                e = {12'(c), ref_mem[b][c]};
            end
        end
        chk(ok, tag, a, e);
        @(negedge clk);
    endtask

    // Wait nb falling edges with done low, then expect the one-cycle pulse.
    task automatic expect_done(input int nb, input logic ap, input logic [1:0] bank,
                               input string tag);
        for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            chk(burst_done == 1'b0, {tag, " done early"}, 32'(burst_done), 0);
        end
        @(negedge clk);
        chk(burst_done == 1'b1, {tag, " done pulse"}, 32'(burst_done), 1);
        chk(pre_req == ap, {tag, " R6 pre_req"}, 32'(pre_req), 32'(ap));
        if (ap) chk(pre_bank == bank, {tag, " R6 pre_bank"}, 32'(pre_bank), 32'(bank));
        @(negedge clk);
        chk(burst_done == 1'b0, {tag, " done width"}, 32'(burst_done), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset.
        chk(burst_done == 1'b0 && pre_req == 1'b0, "R1 reset outputs",
            {31'd0, burst_done | pre_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(burst_done == 1'b0 && pre_req == 1'b0, "R1 after release",
            {31'd0, burst_done | pre_req}, 0);

        // Fill every column with chained unmasked bursts (R2, R8).
        for (int b = 0; b < 4; b++) begin
            for (int k = 0; k < 4; k++) begin
                issue_wr(2'(b), 4'(k * 4), 1'b0, 5.0, 2, 8'(b * 16 + k), 16'h0);
                commit_pair(2'(b), 4'(k * 4), 8'(b * 16 + k), 16'h0, 0);
                commit_pair(2'(b), 4'(k * 4), 8'(b * 16 + k), 16'h0, 1);
                if (!(b == 3 && k == 3)) @(negedge clk);
            end
        end
        repeat (4) @(negedge clk);
        for (int b = 0; b < 4; b++) check_bank(2'(b), "R8 R2 chained fill");

        // Vector table: delays R2, columns R3, masks R4, timing R5, precharge R6.
        for (int v = 0; v < 6; v++) begin
            vec_t t = VECS[v];
            issue_wr(t.bank, t.col, t.ap, dly(t.dsel), 2, t.seed, t.mask);
            expect_done(2, t.ap, t.bank, "R5 vector");
            commit_pair(t.bank, t.col, t.seed, t.mask, 0);
            commit_pair(t.bank, t.col, t.seed, t.mask, 1);
            check_bank(t.bank, "R2 R3 R4 vector contents");
        end

        // R8: chained pair of bursts, no pulse in between.
        issue_wr(2'd1, 4'd8, 1'b0, 3.75, 2, 8'h5A, 16'h0);
        @(negedge clk);
        chk(burst_done == 1'b0, "R8 no mid pulse", 32'(burst_done), 0);
        issue_wr(2'd1, 4'd12, 1'b1, 3.75, 2, 8'h6B, 16'h0024);
        expect_done(2, 1'b1, 2'd1, "R8 chained");
        commit_pair(2'd1, 4'd8, 8'h5A, 16'h0, 0);
        commit_pair(2'd1, 4'd8, 8'h5A, 16'h0, 1);
        commit_pair(2'd1, 4'd12, 8'h6B, 16'h0024, 0);
        commit_pair(2'd1, 4'd12, 8'h6B, 16'h0024, 1);
        check_bank(2'd1, "R8 chained contents");

        // R9: write one cycle after another keeps one pair of the first.
        issue_wr(2'd3, 4'd8, 1'b1, 6.25, 1, 8'h77, 16'h0);
        issue_wr(2'd3, 4'd0, 1'b0, 6.25, 2, 8'h88, 16'h0);
        expect_done(2, 1'b0, 2'd3, "R9 truncation");
        commit_pair(2'd3, 4'd8, 8'h77, 16'h0, 0);
        commit_pair(2'd3, 4'd0, 8'h88, 16'h0, 0);
        commit_pair(2'd3, 4'd0, 8'h88, 16'h0, 1);
        check_bank(2'd3, "R9 truncated contents");

        // R10: read one cycle after the write keeps pair 0 only.
        issue_wr(2'd0, 4'd4, 1'b1, 5.0, 2, 8'h99, 16'h0);
        cmd_rd = 1'b1;
        @(negedge clk);
        cmd_rd = 1'b0;
        chk(burst_done == 1'b0, "R10 done early", 32'(burst_done), 0);
        @(negedge clk);
        chk(burst_done == 1'b1, "R10 done pulse", 32'(burst_done), 1);
        chk(pre_req == 1'b1 && pre_bank == 2'd0, "R10 R6 precharge",
            {30'd0, pre_req, pre_bank[0]}, 32'h2);
        @(negedge clk);
        commit_pair(2'd0, 4'd4, 8'h99, 16'h0, 0);
        check_bank(2'd0, "R10 read cut contents");

        // R7: strobe with no burst in flight.
        fork
            drive_strobe(5.0, 2, 8'h3C, 16'h0);
        join_none
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(burst_done == 1'b0, "R7 no pulse on stray data", 32'(burst_done), 0);
        end
        check_bank(2'd0, "R7 stray data ignored");

        // R11: write and read together; the write is dropped.
        cmd_rd = 1'b1;
        issue_wr(2'd2, 4'd0, 1'b1, 5.0, 2, 8'h4D, 16'h0);
        cmd_rd = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(burst_done == 1'b0, "R11 no pulse", 32'(burst_done), 0);
        end
        check_bank(2'd2, "R11 dropped write");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule